// File: doc/BRIEF.md
# Victim Line Buffer

The victim line buffer is a small fully associative store that sits behind a direct-mapped first-level cache. Every line the first-level cache throws out is pushed into it with its full block number, its data and its modified flag. When the first-level cache misses, it presents the missing block number on the lookup port. All entries compare against it at once. On a match the buffered line goes back to the first-level cache, so a conflict miss costs one cycle instead of a trip to the next level. On no match the buffer forwards the block number to the next level.

A lookup and an eviction may arrive in the same cycle. This is the usual case, because a refill displaces a line. If the lookup hits, the displaced line is written into the slot of the line that was hit, so the two lines trade places. If the lookup misses, or no lookup is present, the displaced line is written into the slot named by a round-robin insertion pointer. Whatever that slot held is lost. If it held a modified line, that line is first sent out as a writeback to the next level.

The buffer holds 4 to 16 entries, set by a parameter. All responses appear one clock after the request.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty and all output valids are 0. The first lookup after reset misses and is forwarded.
- R2: A pushed line that is looked up later returns rsp_hit=1 with its own data and modified flag, one cycle after the lookup.
- R3: A lookup that matches no entry gives fwd_valid=1 with fwd_baddr equal to the looked-up block number and rsp_hit=0, one cycle later. This holds whether or not an eviction is also present that cycle.
- R4: A hit that comes with an eviction stores the evicted line in the slot of the hit line. A later lookup of the evicted block hits, and the insertion pointer does not move.
- R5: A hit that comes without an eviction empties the hit slot. Looking up the same block again misses.
- R6: An eviction that is not part of a hit goes into the slot at the insertion pointer. The pointer then advances by one, wrapping from DEPTH-1 to 0. Pushing DEPTH+1 lines from reset therefore overwrites the first line pushed.
- R7: When a push overwrites a slot holding a valid modified line, wb_valid=1 one cycle later with that line's block number and data. Overwriting a clean line or an empty slot gives wb_valid=0.
- R8: In a cycle with no lookup, rsp_valid and fwd_valid are 0 one cycle later. This holds even when an eviction is pushed.
- R9: A match is found in any slot, including the last one (DEPTH-1), and at most one slot matches a given block number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request after a first-level miss |
| lk_baddr | input | BA_W | Block number looked up |
| ev_valid | input | 1 | Line evicted from the first-level cache |
| ev_baddr | input | BA_W | Block number of the evicted line |
| ev_data | input | LINE_W | Data of the evicted line |
| ev_dirty | input | 1 | Evicted line is modified |
| rsp_valid | output | 1 | Response to last cycle's lookup |
| rsp_hit | output | 1 | Lookup matched an entry |
| rsp_data | output | LINE_W | Data of the matched line (0 on miss) |
| rsp_dirty | output | 1 | Modified flag of the matched line |
| fwd_valid | output | 1 | Request forwarded to the next level |
| fwd_baddr | output | BA_W | Block number forwarded |
| wb_valid | output | 1 | Writeback of a displaced modified line |
| wb_baddr | output | BA_W | Block number written back |
| wb_data | output | LINE_W | Data written back |

## Verification
The assertions assume the first-level cache never pushes a block that is already buffered, and never evicts the block it is looking up in the same cycle. These are the conditions under which at most one slot can match. The stimulus table and the directed sequences use distinct block numbers for every line held at a given time, and each evicted address differs from the lookup address in the same cycle. Inputs stay low during reset, so no assertion sees a push or lookup that starts inside reset.

// File: rtl/vb_pkg.sv
package vb_pkg;

  localparam int VB_MAX_DEPTH = 16;

  // Position of the set bit in a match vector (the vector has at most one set bit).
  function automatic int vb_match_index(input logic [VB_MAX_DEPTH-1:0] vec);
    int idx;
    idx = 0;
    for (int i = 0; i < VB_MAX_DEPTH; i++) begin
      if (vec[i]) idx = i;
    end
    return idx;
  endfunction

  // Round-robin successor of an insertion slot.
  function automatic int vb_ring_next(input int cur, input int depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/vb_entry_array.sv
module vb_entry_array #(
  parameter int DEPTH  = 8,
  parameter int BA_W   = 22,
  parameter int LINE_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [BA_W-1:0]               wr_baddr,
  input  logic [LINE_W-1:0]             wr_data,
  input  logic                          wr_dirty,
  input  logic                          inv_en,
  input  logic [IDX_W-1:0]              inv_idx,
  output logic [DEPTH-1:0]              ent_valid,
  output logic [DEPTH-1:0]              ent_dirty,
  output logic [DEPTH-1:0][BA_W-1:0]    ent_baddr,
  output logic [DEPTH-1:0][LINE_W-1:0]  ent_data
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_dirty[g] <= 1'b0;
        ent_baddr[g] <= '0;
        ent_data[g]  <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        ent_valid[g] <= 1'b1;
        ent_dirty[g] <= wr_dirty;
        ent_baddr[g] <= wr_baddr;
        ent_data[g]  <= wr_data;
      end else if (inv_en && inv_idx == IDX_W'(g)) begin
        ent_valid[g] <= 1'b0;
        ent_dirty[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vb_tag_match.sv
module vb_tag_match #(
  parameter int DEPTH = 8,
  parameter int BA_W  = 22
) (
  input  logic                       lk_valid,
  input  logic [BA_W-1:0]            lk_baddr,
  input  logic [DEPTH-1:0]           ent_valid,
  input  logic [DEPTH-1:0][BA_W-1:0] ent_baddr,
  output logic [DEPTH-1:0]           hit_vec
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = lk_valid && ent_valid[g] && (ent_baddr[g] == lk_baddr);
  end

endmodule

// File: rtl/vb_fifo_ptr.sv
module vb_fifo_ptr #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  import vb_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= IDX_W'(vb_ring_next(int'(ptr), DEPTH));
  end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int DEPTH  = 8,
  parameter int BA_W   = 22,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [BA_W-1:0]   lk_baddr,
  input  logic              ev_valid,
  input  logic [BA_W-1:0]   ev_baddr,
  input  logic [LINE_W-1:0] ev_data,
  input  logic              ev_dirty,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_dirty,
  output logic              fwd_valid,
  output logic [BA_W-1:0]   fwd_baddr,
  output logic              wb_valid,
  output logic [BA_W-1:0]   wb_baddr,
  output logic [LINE_W-1:0] wb_data
);
  import vb_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0]             ent_dirty;
  logic [DEPTH-1:0][BA_W-1:0]   ent_baddr;
  logic [DEPTH-1:0][LINE_W-1:0] ent_data;
  logic [DEPTH-1:0]             hit_vec;
  logic [VB_MAX_DEPTH-1:0]      hit_pad;
  logic [IDX_W-1:0]             hit_idx;
  logic [IDX_W-1:0]             alloc_ptr;
  logic [IDX_W-1:0]             wr_idx;

  // Named events, used by the bound checker
  logic lk_hit;
  logic evt_swap;
  logic evt_alloc;
  logic evt_inv;
  logic evt_wb;

  vb_tag_match #(.DEPTH(DEPTH), .BA_W(BA_W)) u_match (
    .lk_valid (lk_valid),
    .lk_baddr (lk_baddr),
    .ent_valid(ent_valid),
    .ent_baddr(ent_baddr),
    .hit_vec  (hit_vec)
  );

  always_comb begin
    hit_pad = '0;
    hit_pad[DEPTH-1:0] = hit_vec;
    hit_idx = IDX_W'(vb_match_index(hit_pad));
  end

  assign lk_hit    = |hit_vec;
  assign evt_swap  = lk_hit && ev_valid;
  assign evt_inv   = lk_hit && !ev_valid;
  assign evt_alloc = ev_valid && !lk_hit;
  assign evt_wb    = evt_alloc && ent_valid[alloc_ptr] && ent_dirty[alloc_ptr];
  assign wr_idx    = lk_hit ? hit_idx : alloc_ptr;

  vb_fifo_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (evt_alloc),
    .ptr  (alloc_ptr)
  );

  vb_entry_array #(.DEPTH(DEPTH), .BA_W(BA_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ev_valid),
    .wr_idx   (wr_idx),
    .wr_baddr (ev_baddr),
    .wr_data  (ev_data),
    .wr_dirty (ev_dirty),
    .inv_en   (evt_inv),
    .inv_idx  (hit_idx),
    .ent_valid(ent_valid),
    .ent_dirty(ent_dirty),
    .ent_baddr(ent_baddr),
    .ent_data (ent_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
      rsp_dirty <= 1'b0;
      fwd_valid <= 1'b0;
      fwd_baddr <= '0;
      wb_valid  <= 1'b0;
      wb_baddr  <= '0;
      wb_data   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_hit;
      rsp_data  <= lk_hit ? ent_data[hit_idx] : '0;
      rsp_dirty <= lk_hit && ent_dirty[hit_idx];
      fwd_valid <= lk_valid && !lk_hit;
      fwd_baddr <= (lk_valid && !lk_hit) ? lk_baddr : '0;
      wb_valid  <= evt_wb;
      wb_baddr  <= evt_wb ? ent_baddr[alloc_ptr] : '0;
      wb_data   <= evt_wb ? ent_data[alloc_ptr] : '0;
    end
  end

endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int DEPTH = 8,
  parameter int BA_W  = 22,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [BA_W-1:0]  lk_baddr,
  input logic [DEPTH-1:0] hit_vec,
  input logic             evt_alloc,
  input logic [IDX_W-1:0] alloc_ptr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             fwd_valid,
  input logic [BA_W-1:0]  fwd_baddr,
  input logic             wb_valid
);

  p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_miss_forward_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && hit_vec == '0) |=> (fwd_valid && !rsp_hit && fwd_baddr == $past(lk_baddr)));

  p_hit_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && hit_vec != '0) |=> (rsp_valid && rsp_hit && !fwd_valid));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !fwd_valid));

  p_wb_from_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(evt_alloc));

  p_ptr_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alloc |=> alloc_ptr == (($past(alloc_ptr) == IDX_W'(DEPTH-1)) ? '0 : $past(alloc_ptr) + 1'b1));

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_alloc |=> $stable(alloc_ptr));

endmodule

bind victim_buffer vb_checker #(.DEPTH(DEPTH), .BA_W(BA_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_baddr (lk_baddr),
  .hit_vec  (hit_vec),
  .evt_alloc(evt_alloc),
  .alloc_ptr(alloc_ptr),
  .rsp_valid(rsp_valid),
  .rsp_hit  (rsp_hit),
  .fwd_valid(fwd_valid),
  .fwd_baddr(fwd_baddr),
  .wb_valid (wb_valid)
);

// File: tb/tb_victim_buffer.sv
module tb_victim_buffer;

  localparam int PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int BA     = 22;
  localparam int LW     = 32;
  localparam int NVEC   = 19;

  typedef struct packed {
    logic [3:0]    req;
    logic          lk;
    logic [BA-1:0] la;
    logic          ev;
    logic [BA-1:0] ea;
    logic [LW-1:0] ed;
    logic          edt;
    logic          xhit;
    logic [LW-1:0] xdata;
    logic          xdirty;
    logic          xfwd;
    logic          xwb;
    logic [BA-1:0] xwba;
    logic [LW-1:0] xwbd;
  } vec_t;

  // req lk la ev ea ed edt | xhit xdata xdirty xfwd xwb xwba xwbd
  localparam vec_t TBL [NVEC] = '{
    '{4'd8, 1'b0, 22'h000, 1'b0, 22'h000, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R8 idle
    '{4'd3, 1'b1, 22'h100, 1'b0, 22'h000, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 22'h000, 32'h0},        // R3 empty miss
    '{4'd8, 1'b0, 22'h000, 1'b1, 22'h100, 32'h11111111, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R8 push slot0
    '{4'd8, 1'b0, 22'h000, 1'b1, 22'h101, 32'h22222222, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R8 push slot1
    '{4'd2, 1'b1, 22'h101, 1'b0, 22'h000, 32'h0,        1'b0, 1'b1, 32'h22222222, 1'b1, 1'b0, 1'b0, 22'h000, 32'h0},        // R2 hit, empties slot1
    '{4'd5, 1'b1, 22'h101, 1'b0, 22'h000, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 22'h000, 32'h0},        // R5 gone
    '{4'd4, 1'b1, 22'h100, 1'b1, 22'h200, 32'h33333333, 1'b0, 1'b1, 32'h11111111, 1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R4 swap
    '{4'd4, 1'b1, 22'h200, 1'b1, 22'h100, 32'h11111111, 1'b0, 1'b1, 32'h33333333, 1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R4 swap back
    '{4'd6, 1'b0, 22'h000, 1'b1, 22'h300, 32'h44444444, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R6 slot2
    '{4'd6, 1'b0, 22'h000, 1'b1, 22'h301, 32'h55555555, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R6 slot3
    '{4'd7, 1'b0, 22'h000, 1'b1, 22'h302, 32'h66666666, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R7 clean displaced, no wb
    '{4'd6, 1'b1, 22'h100, 1'b0, 22'h000, 32'h0,        1'b0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 22'h000, 32'h0},        // R6 oldest gone
    '{4'd7, 1'b0, 22'h000, 1'b1, 22'h303, 32'h77777777, 1'b0, 1'b0, 32'h0,        1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R7 empty slot, no wb
    '{4'd7, 1'b0, 22'h000, 1'b1, 22'h304, 32'h88888888, 1'b1, 1'b0, 32'h0,        1'b0, 1'b0, 1'b1, 22'h300, 32'h44444444}, // R7 dirty wb
    '{4'd9, 1'b1, 22'h301, 1'b0, 22'h000, 32'h0,        1'b0, 1'b1, 32'h55555555, 1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R9 last slot
    '{4'd4, 1'b1, 22'h302, 1'b1, 22'h305, 32'h99999999, 1'b1, 1'b1, 32'h66666666, 1'b0, 1'b0, 1'b0, 22'h000, 32'h0},        // R4 swap dirty in
    '{4'd2, 1'b1, 22'h305, 1'b0, 22'h000, 32'h0,        1'b0, 1'b1, 32'h99999999, 1'b1, 1'b0, 1'b0, 22'h000, 32'h0},        // R2 dirty flag
    '{4'd3, 1'b1, 22'h400, 1'b1, 22'h500, 32'hAAAAAAAA, 1'b0, 1'b0, 32'h0,        1'b0, 1'b1, 1'b0, 22'h000, 32'h0},        // R3 miss with push
    '{4'd2, 1'b1, 22'h500, 1'b0, 22'h000, 32'h0,        1'b0, 1'b1, 32'hAAAAAAAA, 1'b0, 1'b0, 1'b0, 22'h000, 32'h0}         // R2 pushed on miss
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [BA-1:0] lk_baddr = '0;
  logic          ev_valid = 1'b0;
  logic [BA-1:0] ev_baddr = '0;
  logic [LW-1:0] ev_data = '0;
  logic          ev_dirty = 1'b0;
  logic          rsp_valid, rsp_hit, rsp_dirty, fwd_valid, wb_valid;
  logic [LW-1:0] rsp_data, wb_data;
  logic [BA-1:0] fwd_baddr, wb_baddr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  victim_buffer #(.DEPTH(DEPTH), .BA_W(BA), .LINE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_baddr(lk_baddr),
    .ev_valid(ev_valid), .ev_baddr(ev_baddr), .ev_data(ev_data), .ev_dirty(ev_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
    .fwd_valid(fwd_valid), .fwd_baddr(fwd_baddr),
    .wb_valid(wb_valid), .wb_baddr(wb_baddr), .wb_data(wb_data)
  );

  task automatic check(input string tag, input logic ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one vector at a negedge; the outputs it causes are sampled at the next negedge.
  task automatic run_vec(input vec_t v);
    string tag;
    logic  ok;
    tag = $sformatf("R%0d", v.req);
    lk_valid = v.lk; lk_baddr = v.la;
    ev_valid = v.ev; ev_baddr = v.ea; ev_data = v.ed; ev_dirty = v.edt;
    @(negedge clk);
    lk_valid = 1'b0; ev_valid = 1'b0;
    ok = (rsp_valid == v.lk) && (rsp_hit == v.xhit) && (fwd_valid == v.xfwd) && (wb_valid == v.xwb);
    check(tag, ok, "valids {rsp,hit,fwd,wb}",
          {60'd0, rsp_valid, rsp_hit, fwd_valid, wb_valid},
          {60'd0, v.lk, v.xhit, v.xfwd, v.xwb});
    if (v.xhit)
      check(tag, (rsp_data == v.xdata) && (rsp_dirty == v.xdirty), "hit data/dirty",
            {31'd0, rsp_dirty, rsp_data}, {31'd0, v.xdirty, v.xdata});
    if (v.xfwd)
      check(tag, fwd_baddr == v.la, "fwd_baddr", 64'(fwd_baddr), 64'(v.la));
    if (v.xwb)
      check(tag, (wb_baddr == v.xwba) && (wb_data == v.xwbd), "wb addr/data",
            {10'd0, wb_baddr, wb_data}, {10'd0, v.xwba, v.xwbd});
  endtask

  function automatic vec_t mk(input logic [3:0] r, input logic lk, input logic [BA-1:0] la,
                              input logic ev, input logic [BA-1:0] ea, input logic [LW-1:0] ed,
                              input logic edt, input logic xhit, input logic [LW-1:0] xd,
                              input logic xdt, input logic xfwd, input logic xwb,
                              input logic [BA-1:0] xwba, input logic [LW-1:0] xwbd);
    return '{r, lk, la, ev, ea, ed, edt, xhit, xd, xdt, xfwd, xwb, xwba, xwbd};
  endfunction

  task automatic report;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle while in reset
    check("R1", !rsp_valid && !fwd_valid && !wb_valid && !rsp_hit, "reset outputs",
          {61'd0, rsp_valid, fwd_valid, wb_valid}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) run_vec(TBL[i]);

    // R1: reset in the middle of operation empties every entry
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", !rsp_valid && !fwd_valid && !wb_valid, "outputs under reset",
          {61'd0, rsp_valid, fwd_valid, wb_valid}, 64'd0);
    rst_n = 1'b1;
    run_vec(mk(4'd1, 1'b1, 22'h500, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, '0, '0));

    // R6/R7: DEPTH dirty pushes fill the ring, the next push writes back the first
    for (int k = 0; k < DEPTH; k++)
      run_vec(mk(4'd6, 1'b0, '0, 1'b1, BA'(22'h600 + k), LW'(32'hA0000000 + k), 1'b1,
                 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0));
    run_vec(mk(4'd7, 1'b0, '0, 1'b1, 22'h6FF, 32'hBEEF0000, 1'b1,
               1'b0, '0, 1'b0, 1'b0, 1'b1, 22'h600, 32'hA0000000));
    run_vec(mk(4'd6, 1'b1, 22'h600, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, '0, '0));
    run_vec(mk(4'd6, 1'b1, 22'h601, 1'b0, '0, '0, 1'b0, 1'b1, 32'hA0000001, 1'b1, 1'b0, 1'b0, '0, '0));
    // R9: the newest line sits in slot 0 after the wrap
    run_vec(mk(4'd9, 1'b1, 22'h6FF, 1'b0, '0, '0, 1'b0, 1'b1, 32'hBEEF0000, 1'b1, 1'b0, 1'b0, '0, '0));

    done = 1'b1;
    report();
  end

endmodule